// File: doc/BRIEF.md
# Configurable Dual-Mode Embedded Multiplier

This block is a hard-multiplier-style arithmetic unit. It can act as one wide multiplier or as two independent narrow multipliers. The wide form multiplies two 18-bit operands into a 36-bit product. The split form multiplies the upper halves of the two operand buses together and the lower halves together, giving two separate 18-bit products on one result bus. Both forms use the same set of four half-width partial-product multipliers. The wide form adds the four partial products with shifts. The split form uses only the two diagonal partial products.

Each operand has its own flag that marks it as signed (two's complement) or unsigned. An input register stage and an output register stage can each be switched in or bypassed. The configuration is expected to stay static while the unit is in use, so the latency can be 0, 1 or 2 clocks. A clock enable and a synchronous clear act on the register stages.

Top module: `dual_mult`

## Requirements
- R1: With `mode_i`=0 (wide) and both sign flags low, `p_o` equals the unsigned product of `a_i` and `b_i`. The product is 2*WIDE bits wide, where WIDE = 2*HALF_W.
- R2: With `mode_i`=1 (split), `p_o[2*HALF_W-1:0]` is the product of the low halves `a_i[HALF_W-1:0]` and `b_i[HALF_W-1:0]`. `p_o[4*HALF_W-1:2*HALF_W]` is the product of the high halves. Each product is truncated to 2*HALF_W bits.
- R3: `a_signed_i`=1 makes A a two's-complement value. In split mode this applies to both halves of A. `a_signed_i`=0 makes A unsigned.
- R4: `b_signed_i` does the same for B, independently of A.
- R5: A signed-by-unsigned product sign-extends only the signed operand. The result equals the exact mathematical product in two's complement.
- R6: With `in_reg_en_i`=0 and `out_reg_en_i`=0, `p_o` follows the inputs combinationally, with zero latency.
- R7: With exactly one of the two register enables high, `p_o` shows the product of the inputs sampled one rising edge earlier.
- R8: With both register enables high, `p_o` shows the product of the inputs sampled two rising edges earlier.
- R9: While `ce_i`=0 and `sclr_i`=0, every enabled register holds its value, so `p_o` does not change.
- R10: `sclr_i`=1 at a rising edge zeroes every enabled register, whatever the value of `ce_i`. The output therefore reads 0 after that edge. When both stages are enabled, it also reads 0 one edge later.
- R11: While `rst_ni` is low, all registers are zero, so `p_o` reads 0 whenever at least one stage is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for the register stages |
| sclr_i | input | 1 | Synchronous clear of the enabled stages |
| mode_i | input | 1 | 0 = one wide product, 1 = two half-width products |
| a_signed_i | input | 1 | Operand A is two's complement |
| b_signed_i | input | 1 | Operand B is two's complement |
| in_reg_en_i | input | 1 | Use the input register stage |
| out_reg_en_i | input | 1 | Use the output register stage |
| a_i | input | 2*HALF_W | Operand A |
| b_i | input | 2*HALF_W | Operand B |
| p_o | output | 4*HALF_W | Product bus |

## Verification
The main risk is the wide-mode carry and sign handling between halves, including the sign extension of the cross partial products. An error there corrupts the upper product bits for particular operand patterns, and in combinational mode it is visible at once. The bench therefore sweeps every operand pair of a reduced configuration under all modes and sign settings. A register stage that is misrouted or mis-enabled shows up as a product appearing one edge too early or too late. A broken hold or clear shows up as a changed or non-zero output on the first edge after the stimulus.

// File: rtl/dmul_pkg.sv
package dmul_pkg;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } dmul_mode_e;

  typedef struct packed {
    dmul_mode_e mode;
    logic       a_sgn;
    logic       b_sgn;
  } dmul_cfg_t;
endpackage

// File: rtl/dmul_pp.sv
// One half-width partial product with per-operand sign extension.
module dmul_pp #(
  parameter int W = 9
) (
  input  logic [W-1:0]          x_i,
  input  logic [W-1:0]          y_i,
  input  logic                  xs_i,
  input  logic                  ys_i,
  output logic signed [2*W+1:0] p_o
);
  localparam int PW = 2 * W + 2;

  logic signed [W:0] xe, ye;

  always_comb begin
    xe  = {xs_i & x_i[W-1], x_i};
    ye  = {ys_i & y_i[W-1], y_i};
    p_o = PW'(xe) * PW'(ye);
  end
endmodule

// File: rtl/dmul_stage.sv
// Bypassable register stage with clock enable and synchronous clear.
module dmul_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         sclr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_q <= '0;
    else if (sclr_i) r_q <= '0;   // clear wins over clock enable
    else if (ce_i)   r_q <= d_i;
  end

  assign q_o = en_i ? r_q : d_i;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ce_i && !sclr_i) |=> $stable(q_o) || !$stable(en_i));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sclr_i) |=> (r_q == '0));
endmodule

// File: rtl/dmul_array.sv
// Four half-width partial products; wide mode sums them, split mode uses the diagonals.
module dmul_array
  import dmul_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  input  dmul_cfg_t           cfg_i,
  output logic [4*HALF_W-1:0] p_o
);
  localparam int PPW = 2 * HALF_W + 2;
  localparam int SW  = 4 * HALF_W + 2;
  localparam int HPW = 2 * HALF_W;

  logic split;
  assign split = (cfg_i.mode == MODE_SPLIT);

  logic signed [PPW-1:0] pp [2][2];

  for (genvar ia = 0; ia < 2; ia++) begin : g_a
    for (genvar ib = 0; ib < 2; ib++) begin : g_b
      // Low halves are unsigned magnitude pieces in wide mode.
      logic xs, ys;
      assign xs = cfg_i.a_sgn & ((ia == 1) | split);
      assign ys = cfg_i.b_sgn & ((ib == 1) | split);

      dmul_pp #(.W(HALF_W)) u_pp (
        .x_i  (a_i[ia*HALF_W +: HALF_W]),
        .y_i  (b_i[ib*HALF_W +: HALF_W]),
        .xs_i (xs),
        .ys_i (ys),
        .p_o  (pp[ia][ib])
      );
    end
  end

  logic signed [SW-1:0] hh_x, hl_x, lh_x, ll_x, wide_sum;

  always_comb begin
    hh_x     = SW'(pp[1][1]);
    hl_x     = SW'(pp[1][0]);
    lh_x     = SW'(pp[0][1]);
    ll_x     = SW'(pp[0][0]);
    wide_sum = (hh_x <<< (2 * HALF_W)) + ((hl_x + lh_x) <<< HALF_W) + ll_x;
    if (split) p_o = {pp[1][1][HPW-1:0], pp[0][0][HPW-1:0]};
    else       p_o = wide_sum[4*HALF_W-1:0];
  end
endmodule

// File: rtl/dual_mult.sv
module dual_mult
  import dmul_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_i,
  input  logic                sclr_i,
  input  logic                mode_i,
  input  logic                a_signed_i,
  input  logic                b_signed_i,
  input  logic                in_reg_en_i,
  input  logic                out_reg_en_i,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  output logic [4*HALF_W-1:0] p_o
);
  localparam int OPW = 2 * HALF_W;
  localparam int PW  = 4 * HALF_W;
  localparam int CW  = $bits(dmul_cfg_t);
  localparam int IW  = CW + 2 * OPW;

  dmul_cfg_t       cfg_d, cfg_q;
  logic [OPW-1:0]  a_q, b_q;
  logic [IW-1:0]   in_d, in_q;
  logic [PW-1:0]   prod;

  always_comb begin
    cfg_d.mode  = dmul_mode_e'(mode_i);
    cfg_d.a_sgn = a_signed_i;
    cfg_d.b_sgn = b_signed_i;
    in_d        = {cfg_d, a_i, b_i};
  end

  dmul_stage #(.W(IW)) u_in_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .sclr_i (sclr_i),
    .en_i   (in_reg_en_i),
    .d_i    (in_d),
    .q_o    (in_q)
  );

  assign {cfg_q, a_q, b_q} = in_q;

  dmul_array #(.HALF_W(HALF_W)) u_array (
    .a_i   (a_q),
    .b_i   (b_q),
    .cfg_i (cfg_q),
    .p_o   (prod)
  );

  dmul_stage #(.W(PW)) u_out_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .sclr_i (sclr_i),
    .en_i   (out_reg_en_i),
    .d_i    (prod),
    .q_o    (p_o)
  );

  logic comb_path;
  assign comb_path = !in_reg_en_i && !out_reg_en_i;

  a_r1_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_path && (a_i == '0 || b_i == '0)) |-> (p_o == '0));

  a_r2_low_half_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_path && mode_i && a_i[HALF_W-1:0] == '0) |-> (p_o[OPW-1:0] == '0));

  a_r4_unsigned_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_path && !mode_i && !a_signed_i && !b_signed_i && a_i == OPW'(1))
      |-> (p_o == PW'(b_i)));
endmodule

// File: tb/dual_mult_tb.sv
module dual_mult_tb;
  localparam int H = 3;
  localparam int W = 2 * H;
  localparam int P = 4 * H;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b1, sclr = 1'b0;
  logic mode = 1'b0, as = 1'b0, bs = 1'b0, ien = 1'b0, oen = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [P-1:0] p;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_mult #(.HALF_W(H)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclr_i(sclr), .mode_i(mode),
    .a_signed_i(as), .b_signed_i(bs), .in_reg_en_i(ien), .out_reg_en_i(oen),
    .a_i(a), .b_i(b), .p_o(p)
  );

  function automatic int sx(int v, int w, bit s);
    if (s && v[w-1]) return v - (1 << w);
    return v;
  endfunction

  function automatic logic [P-1:0] model(logic [W-1:0] x, logic [W-1:0] y,
                                         bit m, bit xs, bit ys);
    logic [P-1:0] r;
    int pr;
    if (!m) begin
      pr = sx(int'(x), W, xs) * sx(int'(y), W, ys);
      r  = P'(pr);
    end else begin
      for (int h = 0; h < 2; h++) begin
        pr = sx(int'(x[h*H +: H]), H, xs) * sx(int'(y[h*H +: H]), H, ys);
        r[h*W +: W] = W'(pr);
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [P-1:0] got, logic [P-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h mode=%0b as=%0b bs=%0b)",
               tag, got, exp, a, b, mode, as, bs);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_lat(bit i_en, bit o_en, int lat, string tag);
    logic [P-1:0] q0, q1, e;
    logic [15:0] lfsr = 16'hACE1;
    q0 = '0; q1 = '0;
    @(negedge clk);
    ien = i_en; oen = o_en; ce = 1'b1;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[W-1:0]; b = lfsr[15 -: W];
      mode = k[0]; as = k[1]; bs = k[2];
      e = model(a, b, mode, as, bs);
      if (lat == 0) begin
        #1 check(tag, p, e);
      end
      q1 = q0; q0 = e;
      @(posedge clk); #1;
      if (lat == 1) check(tag, p, q0);
      if (lat == 2 && k >= 1) check(tag, p, q1);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if ($time > 64'd1_500_000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
      end
    end
  end

  initial begin
    logic [P-1:0] hold;
    string tag;

    // R11: reset state with both stages enabled
    ien = 1'b1; oen = 1'b1; a = '1; b = '1;
    #12 check("R11 reset both", p, '0);
    oen = 1'b0;
    #1 check("R11 reset input stage", p, '0);
    @(negedge clk) rst_n = 1'b1;

    // R1..R6: exhaustive combinational sweep
    ien = 1'b0; oen = 1'b0;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        mode = m[0]; as = s[1]; bs = s[0];
        if (mode)            tag = "R2 R6 split";
        else if (s == 0)     tag = "R1 R6 wide unsigned";
        else if (s == 3)     tag = "R3 R4 wide signed";
        else                 tag = "R5 wide mixed";
        for (int x = 0; x < (1 << W); x++)
          for (int y = 0; y < (1 << W); y++) begin
            a = W'(x); b = W'(y);
            #1 check(tag, p, model(a, b, mode, as, bs));
          end
      end

    // R6..R8: latency per register configuration
    run_lat(1'b0, 1'b0, 0, "R6 latency0");
    run_lat(1'b1, 1'b0, 1, "R7 input stage only");
    run_lat(1'b0, 1'b1, 1, "R7 output stage only");
    run_lat(1'b1, 1'b1, 2, "R8 both stages");

    // R9: clock enable freezes both stages
    @(negedge clk);
    ien = 1'b1; oen = 1'b1; ce = 1'b1; mode = 1'b0; as = 1'b1; bs = 1'b0;
    a = 6'h2B; b = 6'h17;
    repeat (2) @(posedge clk);
    #1 check("R8 settle", p, model(6'h2B, 6'h17, 1'b0, 1'b1, 1'b0));
    hold = p;
    @(negedge clk);
    ce = 1'b0; a = 6'h05; b = 6'h3E; mode = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R9 frozen", p, hold);
    @(negedge clk) ce = 1'b1;
    @(posedge clk); #1 check("R9 resume first edge", p, hold);
    @(posedge clk); #1 check("R9 resume second edge", p, model(6'h05, 6'h3E, 1'b1, 1'b1, 1'b0));

    // R10: synchronous clear, both stages, then with ce low
    @(negedge clk) sclr = 1'b1;
    @(posedge clk); #1 check("R10 clear output", p, '0);
    @(negedge clk) sclr = 1'b0;
    @(posedge clk); #1 check("R10 cleared input stage", p, '0);
    @(posedge clk); #1 check("R10 recover", p, model(6'h05, 6'h3E, 1'b1, 1'b1, 1'b0));
    @(negedge clk) begin ce = 1'b0; sclr = 1'b1; end
    @(posedge clk); #1 check("R10 clear with ce low", p, '0);
    @(negedge clk) begin sclr = 1'b0; ce = 1'b1; end

    // R11: asynchronous reset mid-run
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check("R11 async reset", p, '0);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule